// File: doc/BRIEF.md
# UART Interrupt Mask and Routing

This block is the interrupt controller of a memory-mapped serial port. Neighbouring logic (receive FIFO, transmit path, modem-status sampler, error detector) reports events as single-cycle pulses on an 11-bit event input. Each pulse latches a bit in a raw status vector. Software controls which of those bits may reach the interrupt outputs through an enable mask. It reads the raw and the masked vectors through a plain 32-bit register port, and acknowledges events by writing ones to a clear register.

Six level outputs leave the block. Line 0 is the summary of every enabled source. Lines 1 to 3 each follow one source: receive, transmit and receive timeout. Line 4 collects the four modem-status sources and line 5 collects the four receive-error sources. Every output is a flop loaded from the state as it stands after the current cycle's updates. A write to the data register offset also counts as a transmit event, so a transmit interrupt can be raised without a separate pulse.

The register port has no handshake. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i` and the current state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Raw status bit positions are fixed: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10. A pulse on `evt_set_i[k]` sets raw bit k at that clock edge. The raw vector reads at byte offset 0x03C in bits 10:0, and bits 31:11 read as zero.
- R2: The enable mask is read/write at offset 0x038. Bits 10:0 hold the written value and bits 31:11 read as zero.
- R3: Writes to offset 0x03C (raw) and offset 0x040 (masked) change neither the raw vector nor the mask.
- R4: A read at offset 0x040 returns raw AND mask.
- R5: A write to offset 0x044 clears every raw bit that is one in the written value and leaves the others unchanged. A read at 0x044 returns zero.
- R6: When an event pulse and a clear request hit the same bit in the same cycle, the bit ends up set.
- R7: Every write to offset 0x000 sets raw bit 5 (transmit). No transmitter-enable condition applies.
- R8: `irq_o[0]` is high when any bit of raw AND mask is set. Every output is registered and already reflects the state written at the same clock edge.
- R9: `irq_o[1]`, `irq_o[2]` and `irq_o[3]` follow masked bits 4, 5 and 6.
- R10: `irq_o[4]` is the OR of masked bits 3:0, and `irq_o[5]` is the OR of masked bits 10:7.
- R11: While `rst_n` is low, the mask, the raw vector and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_set_i | input | 11 | Event pulses, one per raw status bit |
| irq_o | output | 6 | Interrupt lines: summary, receive, transmit, timeout, modem, error |

## Verification
Sparse random event pulses mixed with random mask and clear writes exercise the mask, raw and masked views against a bench model. They show whether each source reaches only its own line and whether grouped lines OR the right four bits. Directed sequences enable one source at a time, so a wrong bit position or wrong group membership changes a single output. Event and clear are aimed at the same bit in one cycle to show which one wins. Writes to the read-only views, and data writes with the mask enabled or not, separate ignored accesses from side-effecting ones.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 11;
  localparam int NOUT = 6;
  localparam int DW   = 32;

  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;
  localparam int B_PE  = 8;
  localparam int B_BE  = 9;
  localparam int B_OE  = 10;

  typedef logic [NSRC-1:0] irq_vec_t;

  localparam logic [11:0] OFS_DATA = 12'h000;
  localparam logic [11:0] OFS_MASK = 12'h038;
  localparam logic [11:0] OFS_RAW  = 12'h03C;
  localparam logic [11:0] OFS_MSKD = 12'h040;
  localparam logic [11:0] OFS_CLR  = 12'h044;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_RAW, SEL_MSKD, SEL_CLR
  } rd_sel_e;

  // Which raw sources feed each output line
  function automatic irq_vec_t line_sources(input int line);
    irq_vec_t v;
    v = '0;
    case (line)
      0: v = '1;
      1: v[B_RX] = 1'b1;
      2: v[B_TX] = 1'b1;
      3: v[B_RT] = 1'b1;
      4: begin
        v[B_RI] = 1'b1; v[B_CTS] = 1'b1; v[B_DCD] = 1'b1; v[B_DSR] = 1'b1;
      end
      5: begin
        v[B_FE] = 1'b1; v[B_PE] = 1'b1; v[B_BE] = 1'b1; v[B_OE] = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_data_o,
  output logic              wr_mask_o,
  output logic              wr_clr_o,
  output rd_sel_e           rd_sel_o
);
  localparam int AW = (ADDR_W > 12) ? ADDR_W : 12;

  logic [AW-1:0] a;
  assign a = AW'(addr_i);

  function automatic logic hit(input logic [AW-1:0] x, input logic [11:0] ofs);
    return x == AW'(ofs);
  endfunction

  assign wr_data_o = wr_i && hit(a, OFS_DATA);
  assign wr_mask_o = wr_i && hit(a, OFS_MASK);
  assign wr_clr_o  = wr_i && hit(a, OFS_CLR);

  always_comb begin
    rd_sel_o = SEL_NONE;
    if (hit(a, OFS_MASK))      rd_sel_o = SEL_MASK;
    else if (hit(a, OFS_RAW))  rd_sel_o = SEL_RAW;
    else if (hit(a, OFS_MSKD)) rd_sel_o = SEL_MSKD;
    else if (hit(a, OFS_CLR))  rd_sel_o = SEL_CLR;
  end
endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t evt_i,
  input  logic     wr_data_i,
  input  logic     wr_mask_i,
  input  logic     wr_clr_i,
  input  irq_vec_t wdata_i,
  output irq_vec_t raw_q_o,
  output irq_vec_t mask_q_o,
  output irq_vec_t raw_next_o,
  output irq_vec_t mask_next_o
);
  irq_vec_t raw_q, mask_q, set_v, clr_v;

  always_comb begin
    set_v = evt_i;
    set_v[B_TX] = evt_i[B_TX] | wr_data_i;
    clr_v = wr_clr_i ? wdata_i : '0;
    // set dominates a simultaneous clear
    raw_next_o  = (raw_q & ~clr_v) | set_v;
    mask_next_o = wr_mask_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_next_o;
      mask_q <= mask_next_o;
    end
  end

  assign raw_q_o  = raw_q;
  assign mask_q_o = mask_q;
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  irq_vec_t        raw_next_i,
  input  irq_vec_t        mask_next_i,
  output logic [NOUT-1:0] irq_o
);
  irq_vec_t enabled;
  assign enabled = raw_next_i & mask_next_i;

  for (genvar g = 0; g < NOUT; g++) begin : g_line
    localparam irq_vec_t SEL = line_sources(g);
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= |(enabled & SEL);
    end
    assign irq_o[g] = q;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NSRC-1:0]   evt_set_i,
  output logic [NOUT-1:0]   irq_o
);
  logic     wr_data, wr_mask, wr_clr;
  rd_sel_e  rd_sel;
  irq_vec_t raw_q, mask_q, raw_next, mask_next;

  uart_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wr_data_o (wr_data),
    .wr_mask_o (wr_mask),
    .wr_clr_o  (wr_clr),
    .rd_sel_o  (rd_sel)
  );

  uart_irq_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_set_i),
    .wr_data_i   (wr_data),
    .wr_mask_i   (wr_mask),
    .wr_clr_i    (wr_clr),
    .wdata_i     (reg_wdata_i[NSRC-1:0]),
    .raw_q_o     (raw_q),
    .mask_q_o    (mask_q),
    .raw_next_o  (raw_next),
    .mask_next_o (mask_next)
  );

  uart_irq_route u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_next_i  (raw_next),
    .mask_next_i (mask_next),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (rd_sel)
      SEL_MASK: reg_rdata_o[NSRC-1:0] = mask_q;
      SEL_RAW:  reg_rdata_o[NSRC-1:0] = raw_q;
      SEL_MSKD: reg_rdata_o[NSRC-1:0] = raw_q & mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_rdata_o,
  input logic [NSRC-1:0]   evt_set_i,
  input logic [NOUT-1:0]   irq_o,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   mask_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(OFS_MSKD);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  AST_SUMMARY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == |(raw_q & mask_q)); // R8
  AST_MODEM_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[4] == |(raw_q[3:0] & mask_q[3:0])); // R10
  AST_ERROR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[5] == |(raw_q[10:7] & mask_q[10:7])); // R10
  AST_TX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[2] == (raw_q[B_TX] & mask_q[B_TX])); // R9
  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((raw_q & $past(evt_set_i)) == $past(evt_set_i))); // R6
  AST_DATA_SETS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_DATA) |=> raw_q[B_TX]); // R7
  AST_VIEW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_addr_i == A_RAW || reg_addr_i == A_MSKD) && evt_set_i == '0)
      |=> ($stable(raw_q) && $stable(mask_q))); // R3
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_CLR) |-> reg_rdata_o == '0); // R5
  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_MSKD) |-> reg_rdata_o == DW'(raw_q & mask_q)); // R4
endmodule

bind uart_irq_ctrl uart_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .evt_set_i   (evt_set_i),
  .irq_o       (irq_o),
  .raw_q       (raw_q),
  .mask_q      (mask_q)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  import uart_irq_pkg::*;

  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr_i = 1'b0;
  logic [AW-1:0]   reg_addr_i = '0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;
  logic [NSRC-1:0] evt_set_i = '0;
  logic [NOUT-1:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [10:0] m_raw = '0;
  logic [10:0] m_mask = '0;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.ADDR_W(AW)) dut (.*);

  function automatic logic [5:0] exp_irq(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] e;
    e = r & m;
    return {|e[10:7], |e[3:0], e[6], e[5], e[4], |e};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive inputs, apply one edge, update model, return at negedge
  task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [10:0] ev);
    logic [10:0] clr, set;
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d; evt_set_i = ev;
    @(posedge clk);
    set = ev;
    if (wr && a == 12'h000) set[5] = 1'b1;
    clr = (wr && a == 12'h044) ? d[10:0] : 11'h0;
    m_raw = (m_raw & ~clr) | set;
    if (wr && a == 12'h038) m_mask = d[10:0];
    @(negedge clk);
    reg_wr_i = 1'b0; evt_set_i = '0;
    check("R8/R9/R10 irq", {26'h0, irq_o}, {26'h0, exp_irq(m_raw, m_mask)});
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_wr_i = 1'b0; reg_addr_i = a;
    #0.5;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic read_all();
    rd(12'h03C, {21'h0, m_raw}, "R1 raw view");
    rd(12'h038, {21'h0, m_mask}, "R2 mask view");
    rd(12'h040, {21'h0, m_raw & m_mask}, "R4 masked view");
    rd(12'h044, 32'h0, "R5 clear reads zero");
  endtask

  initial begin : watchdog
    #400000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    // R11: reset state with events and writes active
    reg_wr_i = 1'b1; reg_addr_i = 12'h038; reg_wdata_i = 32'h7FF; evt_set_i = 11'h7FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_wr_i = 1'b0; evt_set_i = '0;
    check("R11 irq in reset", {26'h0, irq_o}, 32'h0);
    rd(12'h03C, 32'h0, "R11 raw in reset");
    rd(12'h038, 32'h0, "R11 mask in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: upper bits read zero
    step(1'b1, 12'h038, 32'hFFFF_FFFF, 11'h0);
    read_all();
    step(1'b1, 12'h038, 32'h0, 11'h0);

    // R1/R9/R10: walk each source alone with full mask
    step(1'b1, 12'h038, 32'h7FF, 11'h0);
    for (int k = 0; k < NSRC; k++) begin
      step(1'b0, 12'h000, 32'h0, 11'(1) << k);
      rd(12'h03C, 32'(1) << k, "R1 bit position");
      step(1'b1, 12'h044, 32'h7FF, 11'h0);
    end

    // R6: set wins over clear on the same bit
    step(1'b1, 12'h044, 32'h7FF, 11'h010);
    rd(12'h03C, 32'h010, "R6 set beats clear");
    // R5: partial clear
    step(1'b0, 12'h000, 32'h0, 11'h3C3);
    step(1'b1, 12'h044, 32'h0C1, 11'h0);
    rd(12'h03C, {21'h0, m_raw}, "R5 partial clear");

    // R3: writes to view offsets ignored
    step(1'b1, 12'h03C, 32'h0, 11'h0);
    rd(12'h03C, {21'h0, m_raw}, "R3 raw write ignored");
    step(1'b1, 12'h040, 32'hFFFF_FFFF, 11'h0);
    rd(12'h038, {21'h0, m_mask}, "R3 masked write ignored");

    // R7: data write sets TX, with mask off and on
    step(1'b1, 12'h044, 32'h7FF, 11'h0);
    step(1'b1, 12'h038, 32'h0, 11'h0);
    step(1'b1, 12'h000, 32'h41, 11'h0);
    rd(12'h03C, 32'h020, "R7 data write sets tx");
    check("R7 tx line masked off", {31'h0, irq_o[2]}, 32'h0);
    step(1'b1, 12'h038, 32'h020, 11'h0);
    check("R9 tx line after enable", {31'h0, irq_o[2]}, 32'h1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [10:0] ev;
      op = $urandom_range(0, 9);
      ev = ($urandom_range(0, 3) == 0) ? 11'($urandom) : 11'h0;
      case (op)
        0, 1: step(1'b1, 12'h038, $urandom, ev);
        2, 3: step(1'b1, 12'h044, $urandom, ev);
        4:    step(1'b1, 12'h03C, $urandom, ev);
        5:    step(1'b1, 12'h040, $urandom, ev);
        6:    step(1'b1, 12'h000, $urandom, ev);
        default: step(1'b0, 12'h000, 32'h0, ev);
      endcase
      if (i % 4 == 0) read_all();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule